// File: doc/BRIEF.md
# Character LCD Register Bridge

This block lets an 8-bit microcontroller drive a parallel character LCD through ordinary external-memory writes. The microcontroller presents the low half of each address and then the data on one shared 8-bit port, the upper address byte on a separate port, an address latch strobe, and an active-low write strobe. The bridge brings the strobes into its own clock domain through two-flop synchronizers. It captures both address bytes when the latch strobe falls and commits a register write when the write strobe rises again.

Three upper-address pages are decoded. One page loads the full byte that appears on the LCD data pins. One page sets the register-select line from data bit 0. One page sets the enable line from data bit 0. Software forms each enable pulse from two writes, 1 and then 0. The read/write line is held at the write level. The block only listens to the microcontroller bus and never drives it. Command ordering and busy polling are left to software.

Top module: `lcd_bus_bridge`

## Requirements
- R1: While rst_n is low, and at its release, lcd_d is 0x00 and lcd_e, lcd_rs and lcd_rw are all 0.
- R2: A write whose latched upper address byte is 0xF3 loads all 8 data bits into lcd_d.
- R3: A write to upper page 0xF0 sets lcd_rs to data bit 0 (1 = character data, 0 = command). Data bits 7..1 have no effect.
- R4: A write to upper page 0xF1 sets lcd_e to data bit 0, so the two writes 1 then 0 produce one enable pulse. lcd_d and lcd_rs do not move during that pulse.
- R5: lcd_rw stays 0 (write direction) at all times after reset, whatever is written to any page.
- R6: A write to any upper page other than 0xF0, 0xF1 and 0xF3 (for example 0xF2, 0xF4, 0x00, 0x73) leaves lcd_d, lcd_e and lcd_rs unchanged.
- R7: A register changes only after the write strobe returns high. While wr_n is low the outputs hold their old values. The new value appears within 3 clock edges of the rising edge of wr_n.
- R8: The upper and low address bytes are captured when ale falls. A change on ha or ad after that edge does not alter which page the write reaches. With the default low-address mask of 0x00, every low address byte is accepted.
- R9: The internal control word places R/W at bit 0, E at bit 1 and RS at bit 2, and each output pin follows its own bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, much faster than the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch strobe, active high; the address is taken on its falling edge |
| wr_n | input | 1 | Active-low write strobe; the write commits on its rising edge |
| ad | input | 8 | Shared low-address / data port (never driven by the block) |
| ha | input | 8 | Upper address byte, selects the register page |
| lcd_d | output | 8 | LCD data pins D0..D7 |
| lcd_e | output | 1 | LCD enable |
| lcd_rs | output | 1 | LCD register select |
| lcd_rw | output | 1 | LCD read/write, held at write (0) |

## Verification
If the captured page or the held write byte is wrong, one of the LCD pins shows a wrong value no later than the third clock edge after wr_n rises. That pin may be lcd_d, lcd_rs or lcd_e, depending on the page. A hit decoded on the wrong strobe edge shows up as an output that moves while wr_n is still low. A wrong address capture shows up as a write that lands on the page placed on ha after ale fell, instead of the page latched at that edge. An error in the control word shows at once as an enable or select pin that moves on a write to another page, or as lcd_rw leaving 0.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_RS   = 2'd1,
    PG_EN   = 2'd2,
    PG_DATA = 2'd3
  } page_e;

  // bit 2 = RS, bit 1 = E, bit 0 = R/W
  typedef struct packed {
    logic rs;
    logic en;
    logic rw;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{rs: 1'b0, en: 1'b0, rw: 1'b0};

  function automatic logic low_ok(input logic [BYTE_W-1:0] lo,
                                  input logic [BYTE_W-1:0] mask,
                                  input logic [BYTE_W-1:0] match);
    return ((lo ^ match) & mask) == '0;
  endfunction

  function automatic page_e page_of(input logic [BYTE_W-1:0] hi,
                                    input logic [BYTE_W-1:0] lo,
                                    input logic [BYTE_W-1:0] pg_rs,
                                    input logic [BYTE_W-1:0] pg_en,
                                    input logic [BYTE_W-1:0] pg_data,
                                    input logic [BYTE_W-1:0] mask,
                                    input logic [BYTE_W-1:0] match);
    page_e p;
    p = PG_NONE;
    if (low_ok(lo, mask, match)) begin
      if (hi == pg_data)     p = PG_DATA;
      else if (hi == pg_rs)  p = PG_RS;
      else if (hi == pg_en)  p = PG_EN;
    end
    return p;
  endfunction

endpackage

// File: rtl/lcdb_sync_pipe.sv
module lcdb_sync_pipe #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lcdb_strobe_edge.sv
module lcdb_strobe_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b0,
  parameter bit   RISING  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic lvl,
  output logic evt
);
  logic prev;

  lcdb_sync_pipe #(.W(1), .STAGES(STAGES), .RST_VAL(RST_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe), .q(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_LVL;
    else        prev <= lvl;
  end

  generate
    if (RISING) begin : g_rise
      assign evt = lvl & ~prev;
    end else begin : g_fall
      assign evt = ~lvl & prev;
    end
  endgenerate
endmodule

// File: rtl/lcdb_bus_capture.sv
module lcdb_bus_capture
  import lcdb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_lvl,
  input  logic              ale_fall,
  input  logic              wr_lvl,
  input  logic [BYTE_W-1:0] ad_s,
  input  logic [BYTE_W-1:0] ha_s,
  output logic [BYTE_W-1:0] lo_addr,
  output logic [BYTE_W-1:0] hi_addr,
  output logic [BYTE_W-1:0] wr_byte
);
  logic [BYTE_W-1:0] lo_track, hi_track;

  // follow the bus while ale is high, freeze on its falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_track <= '0;
      hi_track <= '0;
      lo_addr  <= '0;
      hi_addr  <= '0;
    end else begin
      if (ale_lvl) begin
        lo_track <= ad_s;
        hi_track <= ha_s;
      end
      if (ale_fall) begin
        lo_addr <= lo_track;
        hi_addr <= hi_track;
      end
    end
  end

  // keep the last byte seen while the write strobe was low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_byte <= '0;
    else if (!wr_lvl) wr_byte <= ad_s;
  end
endmodule

// File: rtl/lcdb_lcd_regs.sv
module lcdb_lcd_regs
  import lcdb_pkg::*;
#(
  parameter logic [7:0] PAGE_RS   = 8'hF0,
  parameter logic [7:0] PAGE_EN   = 8'hF1,
  parameter logic [7:0] PAGE_DATA = 8'hF3,
  parameter logic [7:0] LO_MASK   = 8'h00,
  parameter logic [7:0] LO_MATCH  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rise,
  input  logic [BYTE_W-1:0] hi_addr,
  input  logic [BYTE_W-1:0] lo_addr,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              hit_data,
  output logic              hit_rs,
  output logic              hit_en,
  output logic [BYTE_W-1:0] data_q,
  output ctrl_t             ctrl_q
);
  page_e page;

  always_comb begin
    page = page_of(hi_addr, lo_addr, PAGE_RS, PAGE_EN, PAGE_DATA, LO_MASK, LO_MATCH);
  end

  assign hit_data = wr_rise && (page == PG_DATA);
  assign hit_rs   = wr_rise && (page == PG_RS);
  assign hit_en   = wr_rise && (page == PG_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= CTRL_RESET;
    end else begin
      if (hit_data) data_q    <= wr_byte;
      if (hit_rs)   ctrl_q.rs <= wr_byte[0];
      if (hit_en)   ctrl_q.en <= wr_byte[0];
      ctrl_q.rw <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_bus_bridge.sv
module lcd_bus_bridge
  import lcdb_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] PAGE_RS     = 8'hF0,
  parameter logic [7:0] PAGE_EN     = 8'hF1,
  parameter logic [7:0] PAGE_DATA   = 8'hF3,
  parameter logic [7:0] LO_MASK     = 8'h00,
  parameter logic [7:0] LO_MATCH    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale,
  input  logic       wr_n,
  input  logic [7:0] ad,
  input  logic [7:0] ha,
  output logic [7:0] lcd_d,
  output logic       lcd_e,
  output logic       lcd_rs,
  output logic       lcd_rw
);
  logic              ale_lvl, ale_fall;
  logic              wr_lvl, wr_rise;
  logic [BYTE_W-1:0] ad_s, ha_s;
  logic [BYTE_W-1:0] lo_addr, hi_addr, wr_byte;
  logic              hit_data, hit_rs, hit_en;
  logic [BYTE_W-1:0] data_q;
  ctrl_t             ctrl_q;

  lcdb_strobe_edge #(.STAGES(SYNC_STAGES), .RST_LVL(1'b0), .RISING(1'b0)) u_ale (
    .clk(clk), .rst_n(rst_n), .strobe(ale), .lvl(ale_lvl), .evt(ale_fall)
  );

  lcdb_strobe_edge #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1), .RISING(1'b1)) u_wr (
    .clk(clk), .rst_n(rst_n), .strobe(wr_n), .lvl(wr_lvl), .evt(wr_rise)
  );

  // bus bytes delayed by the same depth as the strobes so they stay aligned
  lcdb_sync_pipe #(.W(2*BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus (
    .clk(clk), .rst_n(rst_n), .d({ha, ad}), .q({ha_s, ad_s})
  );

  lcdb_bus_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .ale_lvl(ale_lvl), .ale_fall(ale_fall), .wr_lvl(wr_lvl),
    .ad_s(ad_s), .ha_s(ha_s),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .wr_byte(wr_byte)
  );

  lcdb_lcd_regs #(
    .PAGE_RS(PAGE_RS), .PAGE_EN(PAGE_EN), .PAGE_DATA(PAGE_DATA),
    .LO_MASK(LO_MASK), .LO_MATCH(LO_MATCH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise),
    .hi_addr(hi_addr), .lo_addr(lo_addr), .wr_byte(wr_byte),
    .hit_data(hit_data), .hit_rs(hit_rs), .hit_en(hit_en),
    .data_q(data_q), .ctrl_q(ctrl_q)
  );

  assign lcd_d  = data_q;
  assign lcd_rw = ctrl_q.rw;
  assign lcd_e  = ctrl_q.en;
  assign lcd_rs = ctrl_q.rs;
endmodule

// File: rtl/lcd_bus_bridge_chk.sv
module lcd_bus_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_rise,
  input logic       hit_data,
  input logic       hit_rs,
  input logic       hit_en,
  input logic [7:0] wr_byte,
  input logic [7:0] lcd_d,
  input logic       lcd_e,
  input logic       lcd_rs,
  input logic       lcd_rw
);
  // R5
  rw_write_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw == 1'b0);

  // R2
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_data |=> lcd_d == $past(wr_byte));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_data |=> $stable(lcd_d));

  // R3
  rs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rs |=> lcd_rs == $past(wr_byte[0]));

  // R6
  rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_rs |=> $stable(lcd_rs));

  // R4
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en |=> lcd_e == $past(wr_byte[0]));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_en |=> $stable(lcd_e));

  // R7
  hit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data || hit_rs || hit_en) |-> wr_rise);

  // R6
  one_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_data, hit_rs, hit_en}));
endmodule

bind lcd_bus_bridge lcd_bus_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise),
  .hit_data(hit_data), .hit_rs(hit_rs), .hit_en(hit_en),
  .wr_byte(wr_byte), .lcd_d(lcd_d), .lcd_e(lcd_e),
  .lcd_rs(lcd_rs), .lcd_rw(lcd_rw)
);

// File: tb/sim_lcd_bus_bridge.sv
`timescale 1ns/1ps
module sim_lcd_bus_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic       wr_n = 1'b1;
  logic [7:0] ad = 8'h00;
  logic [7:0] ha = 8'h00;
  logic [7:0] lcd_d;
  logic       lcd_e, lcd_rs, lcd_rw;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcd_bus_bridge u0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .wr_n(wr_n), .ad(ad), .ha(ha),
    .lcd_d(lcd_d), .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw)
  );

  // {page, low addr, data, expected lcd_d, expected e, expected rs}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {8'hF3, 8'h00, 8'h3F, 8'h3F, 1'b0, 1'b0},
    {8'hF0, 8'h00, 8'h01, 8'h3F, 1'b0, 1'b1},
    {8'hF0, 8'h5A, 8'hFE, 8'h3F, 1'b0, 1'b0},
    {8'hF1, 8'h00, 8'h01, 8'h3F, 1'b1, 1'b0},
    {8'hF1, 8'h00, 8'h00, 8'h3F, 1'b0, 1'b0},
    {8'hF2, 8'h00, 8'hFF, 8'h3F, 1'b0, 1'b0},
    {8'hF3, 8'hC3, 8'hA5, 8'hA5, 1'b0, 1'b0},
    {8'h00, 8'h00, 8'h55, 8'hA5, 1'b0, 1'b0},
    {8'hF4, 8'h00, 8'h01, 8'hA5, 1'b0, 1'b0},
    {8'hF0, 8'hFF, 8'h03, 8'hA5, 1'b0, 1'b1},
    {8'hF3, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1},
    {8'h73, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk);
    ale = 1'b1; ad = lo; ha = hi;
    cyc(3);
    ale = 1'b0;
    cyc(2);
  endtask

  task automatic data_low(input logic [7:0] dat, input logic [7:0] hi_late, input int n);
    ad = dat; ha = hi_late; wr_n = 1'b0;
    cyc(n);
  endtask

  task automatic bus_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] dat);
    addr_phase(hi, lo);
    data_low(dat, hi, 4);
    wr_n = 1'b1;
    cyc(6);
  endtask

  initial begin
    cyc(3);
    // R1 during reset
    check("R1 lcd_d", lcd_d, 8'h00);
    check("R1 e/rs/rw", {5'd0, lcd_rs, lcd_e, lcd_rw}, 8'h00);
    rst_n = 1'b1;
    cyc(2);
    check("R1 after release", {lcd_d}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] pg, lo, dat, ed;
      logic ee, ers;
      string tag;
      {pg, lo, dat, ed, ee, ers} = VEC[i];
      tag = (pg == 8'hF3) ? "R2" : (pg == 8'hF0) ? "R3" :
            (pg == 8'hF1) ? "R4" : "R6";
      bus_write(pg, lo, dat);
      check({tag, " lcd_d"}, lcd_d, ed);
      check({tag, " lcd_e"}, {7'd0, lcd_e}, {7'd0, ee});
      check({tag, " lcd_rs"}, {7'd0, lcd_rs}, {7'd0, ers});
      check("R5 lcd_rw", {7'd0, lcd_rw}, 8'h00);
    end

    // R9: control bits land on their own pins only
    bus_write(8'hF1, 8'h00, 8'h06);
    check("R9 e from bit0 only", {5'd0, lcd_rs, lcd_e, lcd_rw}, 8'h04);
    bus_write(8'hF0, 8'h00, 8'h00);
    check("R9 rs cleared, e kept", {5'd0, lcd_rs, lcd_e, lcd_rw}, 8'h00);

    // R7: hold while strobe low, update within 3 edges after release
    addr_phase(8'hF3, 8'h00);
    data_low(8'h99, 8'hF3, 6);
    check("R7 hold while wr_n low", lcd_d, 8'h00);
    wr_n = 1'b1;
    cyc(3);
    check("R7 update latency", lcd_d, 8'h99);
    cyc(4);

    // R8: ha changes after ale falls; the latched page wins
    addr_phase(8'hF0, 8'h12);
    data_low(8'h01, 8'hF3, 4);
    wr_n = 1'b1;
    cyc(6);
    check("R8 page latched at ale", {7'd0, lcd_rs}, 8'h01);
    check("R8 data page untouched", lcd_d, 8'h99);

    // R4: enable pulse leaves data and rs alone
    bus_write(8'hF1, 8'h00, 8'h01);
    check("R4 pulse high", {5'd0, lcd_rs, lcd_e, lcd_rw}, 8'h06);
    check("R4 data stable", lcd_d, 8'h99);
    bus_write(8'hF1, 8'h00, 8'h00);
    check("R4 pulse low", {5'd0, lcd_rs, lcd_e, lcd_rw}, 8'h04);

    // R1: mid-run reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    cyc(2);
    check("R1 mid-run reset", {lcd_d}, 8'h00);
    check("R1 mid-run ctrl", {5'd0, lcd_rs, lcd_e, lcd_rw}, 8'h00);
    rst_n = 1'b1;
    cyc(3);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule